// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a clocked static memory whose words are 36 bits wide: four byte lanes of 8 data bits plus one parity bit each. Address and control inputs are captured on the rising clock edge. An access can begin a four-beat burst, and a 2-bit internal counter supplies the two lowest address bits of the beats that follow. A burst opens on either of two active-low start strobes. One serves the processor and the other the cache controller. An active-low step input moves the counter forward. A static order input selects linear or interleaved beat order.

Reads go through two register stages: the access register and the output register. Writes are captured together with their data and committed to the array on the next edge. Three chip selects allow depth expansion without bus contention. The output drive is removed one edge after a deselect but appears only two edges after a select. An output-enable input and a sleep input act on the output drive without waiting for the clock.

Top module: `pburst_sram`

## Requirements
- R1: While `rst` is high at a rising edge, `rdata_drive` goes low and any open burst is abandoned, so an access after reset needs a start strobe.
- R2: A read accepted at edge k presents its word on `rdata` with `rdata_drive` high after edge k+1, provided `out_en_n` is low and `sleep` is low.
- R3: With `order_linear` = 1, the low two address bits of beat i are (start low bits + i) mod 4. The upper address bits stay fixed for the whole burst.
- R4: With `order_linear` = 0, the low two address bits of beat i are the start low bits XOR i.
- R5: In a cycle with no start strobe and an open burst, the beat counter steps when `step_n` is low. When `step_n` is high it holds, and the same address is accessed again.
- R6: The processor strobe `start_cpu_n` always begins a read, whatever the write inputs are. It is ignored entirely while `sel1_n` is high.
- R7: The controller strobe `start_ctl_n` begins a write when the write inputs request one and a read otherwise. If both strobes are accepted in the same cycle, the processor strobe wins. Continuation beats take their type from the write inputs.
- R8: A low `wr_all_n` writes all four lanes. Otherwise lane b (bits 9b+8 down to 9b) is written only when `wr_bytes_n` is low and `lane_wr_n[b]` is low.
- R9: A strobe taken while the chip is not selected (selected means `sel1_n`=0, `sel2`=1 and `sel3_n`=0) closes the burst and drops `rdata_drive` after that edge. A select after a deselect raises it only after the second edge.
- R10: A high `out_en_n` forces `rdata_drive` low at once, without waiting for a clock edge.
- R11: While `sleep` is high, `rdata_drive` is low at once, no access or write is accepted, and the burst position is held so that stepping resumes from it afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Word address |
| start_cpu_n | input | 1 | Processor burst-start strobe, active low |
| start_ctl_n | input | 1 | Controller burst-start strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| sel1_n | input | 1 | Chip select 1, active low; also gates the processor strobe |
| sel2 | input | 1 | Chip select 2, active high |
| sel3_n | input | 1 | Chip select 3, active low |
| wr_all_n | input | 1 | Whole-word write enable, active low |
| wr_bytes_n | input | 1 | Lane-write qualifier, active low |
| lane_wr_n | input | NBYTES | Per-lane write enables, active low |
| order_linear | input | 1 | 1 = linear beat order, 0 = interleaved |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Power-down request, active high |
| wdata | input | NBYTES*BYTE_W | Write data |
| rdata | output | NBYTES*BYTE_W | Read data from the output register |
| rdata_drive | output | 1 | High when the data outputs would be driven |

## Verification
The array is first filled with an address-derived word. Every address is then read as a single access, with write inputs held active on the processor reads, so that a processor-strobe read that wrote would show up. Bursts are run from every start offset of every 4-word block in both orders. Linear and interleaved order give identical beats only at offsets 0 and 2, so the sweep tells the two orders apart and also catches counter wrap errors. All sixteen lane masks are written and read back, which separates the lanes from one another. Separate sequences check step holds, a mixed strobe cycle, a blocked processor strobe, select/deselect latency, output enable and a sleep that interrupts a burst.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
  localparam int BEAT_W = 2;
  typedef logic [BEAT_W-1:0] beat_t;

  // low address bits for a beat, given the burst start and beat count
  function automatic beat_t beat_addr(beat_t base, beat_t cnt, logic lin);
    beat_t r;
    if (lin) r = beat_t'(base + cnt);
    else     r = base ^ cnt;
    return r;
  endfunction
endpackage

// File: rtl/pbs_burst_ctrl.sv
module pbs_burst_ctrl
  import pbs_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 4,
  parameter int BYTE_W = 9
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [ADDR_W-1:0]          addr,
  input  logic                       start_cpu_n,
  input  logic                       start_ctl_n,
  input  logic                       step_n,
  input  logic                       sel1_n,
  input  logic                       sel2,
  input  logic                       sel3_n,
  input  logic                       wr_all_n,
  input  logic                       wr_bytes_n,
  input  logic [NBYTES-1:0]          lane_wr_n,
  input  logic                       order_linear,
  input  logic                       sleep,
  input  logic [NBYTES*BYTE_W-1:0]   wdata,
  output logic                       s1_valid,
  output logic                       s1_wr,
  output logic [NBYTES-1:0]          s1_mask,
  output logic [ADDR_W-1:0]          s1_addr,
  output logic [NBYTES*BYTE_W-1:0]   s1_data,
  output logic                       kill,
  output logic                       burst_act
);
  localparam int DATA_W = NBYTES * BYTE_W;
  localparam int HI_W   = ADDR_W - BEAT_W;

  logic              chip_sel, cpu_go, ctl_go, any_strobe;
  logic              take_start, take_desel, take_cont;
  logic              wr_req, acc_wr;
  logic [NBYTES-1:0] wmask;
  beat_t             base_q, beat_q, base_n, beat_n, lo_bits;
  logic [HI_W-1:0]   hi_q, hi_n;

  always_comb begin
    chip_sel   = !sel1_n && sel2 && !sel3_n;
    cpu_go     = !start_cpu_n && !sel1_n;
    ctl_go     = !start_ctl_n && !cpu_go;
    any_strobe = cpu_go || ctl_go;
    take_start = any_strobe && chip_sel && !sleep;
    take_desel = any_strobe && !chip_sel && !sleep;
    take_cont  = !any_strobe && burst_act && !sleep;
    kill       = take_desel || sleep;

    if (!wr_all_n)        wmask = '1;
    else if (!wr_bytes_n) wmask = ~lane_wr_n;
    else                  wmask = '0;
    wr_req = |wmask;
    acc_wr = cpu_go ? 1'b0 : wr_req;

    if (take_start) begin
      hi_n   = addr[ADDR_W-1:BEAT_W];
      base_n = addr[BEAT_W-1:0];
      beat_n = '0;
    end else begin
      hi_n   = hi_q;
      base_n = base_q;
      beat_n = (take_cont && !step_n) ? beat_t'(beat_q + 1'b1) : beat_q;
    end
    lo_bits = beat_addr(base_n, beat_n, order_linear);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      burst_act <= 1'b0;
      s1_valid  <= 1'b0;
      s1_wr     <= 1'b0;
      s1_mask   <= '0;
      hi_q      <= '0;
      base_q    <= '0;
      beat_q    <= '0;
    end else begin
      if (take_start)      burst_act <= 1'b1;
      else if (take_desel) burst_act <= 1'b0;
      if (take_start || take_cont) begin
        hi_q   <= hi_n;
        base_q <= base_n;
        beat_q <= beat_n;
      end
      s1_valid <= take_start || take_cont;
      s1_wr    <= (take_start || take_cont) && acc_wr;
      s1_mask  <= acc_wr ? wmask : '0;
    end
  end

  // address and data-in registers carry no reset
  always_ff @(posedge clk) begin
    s1_addr <= {hi_n, lo_bits};
    s1_data <= wdata;
  end

  logic [DATA_W-1:0] unused_w;
  assign unused_w = '0;
endmodule

// File: rtl/pbs_array.sv
module pbs_array #(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 4,
  parameter int BYTE_W = 9
) (
  input  logic                      clk,
  input  logic                      s1_valid,
  input  logic                      s1_wr,
  input  logic [NBYTES-1:0]         s1_mask,
  input  logic [ADDR_W-1:0]         s1_addr,
  input  logic [NBYTES*BYTE_W-1:0]  s1_data,
  output logic [NBYTES*BYTE_W-1:0]  rd_q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic rd_en;
  assign rd_en = s1_valid && !s1_wr;

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    logic [BYTE_W-1:0] mem [DEPTH];
    logic [BYTE_W-1:0] lane_q;
    logic              lane_we;
    assign lane_we = s1_valid && s1_wr && s1_mask[b];
    always_ff @(posedge clk) begin
      if (lane_we) mem[s1_addr] <= s1_data[b*BYTE_W +: BYTE_W];
      if (rd_en)   lane_q <= mem[s1_addr];
    end
    assign rd_q[b*BYTE_W +: BYTE_W] = lane_q;
  end
endmodule

// File: rtl/pbs_out_stage.sv
module pbs_out_stage (
  input  logic clk,
  input  logic rst,
  input  logic s1_valid,
  input  logic s1_wr,
  input  logic kill,
  input  logic out_en_n,
  input  logic sleep,
  output logic rdata_drive
);
  logic drive_q;

  always_ff @(posedge clk) begin
    if (rst) drive_q <= 1'b0;
    else     drive_q <= s1_valid && !s1_wr && !kill;
  end

  assign rdata_drive = drive_q && !out_en_n && !sleep;
endmodule

// File: rtl/pburst_sram.sv
module pburst_sram #(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 4,
  parameter int BYTE_W = 9
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [ADDR_W-1:0]         addr,
  input  logic                      start_cpu_n,
  input  logic                      start_ctl_n,
  input  logic                      step_n,
  input  logic                      sel1_n,
  input  logic                      sel2,
  input  logic                      sel3_n,
  input  logic                      wr_all_n,
  input  logic                      wr_bytes_n,
  input  logic [NBYTES-1:0]         lane_wr_n,
  input  logic                      order_linear,
  input  logic                      out_en_n,
  input  logic                      sleep,
  input  logic [NBYTES*BYTE_W-1:0]  wdata,
  output logic [NBYTES*BYTE_W-1:0]  rdata,
  output logic                      rdata_drive
);
  localparam int DATA_W = NBYTES * BYTE_W;

  logic              s1_valid, s1_wr, kill, burst_act;
  logic [NBYTES-1:0] s1_mask;
  logic [ADDR_W-1:0] s1_addr;
  logic [DATA_W-1:0] s1_data;

  pbs_burst_ctrl #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_ctrl (
    .clk(clk), .rst(rst), .addr(addr),
    .start_cpu_n(start_cpu_n), .start_ctl_n(start_ctl_n), .step_n(step_n),
    .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
    .wr_all_n(wr_all_n), .wr_bytes_n(wr_bytes_n), .lane_wr_n(lane_wr_n),
    .order_linear(order_linear), .sleep(sleep), .wdata(wdata),
    .s1_valid(s1_valid), .s1_wr(s1_wr), .s1_mask(s1_mask),
    .s1_addr(s1_addr), .s1_data(s1_data), .kill(kill), .burst_act(burst_act)
  );

  pbs_array #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_array (
    .clk(clk), .s1_valid(s1_valid), .s1_wr(s1_wr), .s1_mask(s1_mask),
    .s1_addr(s1_addr), .s1_data(s1_data), .rd_q(rdata)
  );

  pbs_out_stage u_out (
    .clk(clk), .rst(rst), .s1_valid(s1_valid), .s1_wr(s1_wr), .kill(kill),
    .out_en_n(out_en_n), .sleep(sleep), .rdata_drive(rdata_drive)
  );
endmodule

// File: rtl/pbs_checker.sv
module pbs_checker (
  input logic clk,
  input logic rst,
  input logic start_cpu_n,
  input logic start_ctl_n,
  input logic sel1_n,
  input logic sel2,
  input logic sel3_n,
  input logic sleep,
  input logic out_en_n,
  input logic rdata_drive,
  input logic s1_valid,
  input logic s1_wr,
  input logic burst_act
);
  // R1
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!s1_valid && !burst_act));

  // R6: processor strobe blocked by sel1_n
  a_r6_cpu_blocked: assert property (@(posedge clk) disable iff (rst)
    (sel1_n && start_ctl_n && !burst_act) |=> !s1_valid);

  // R6: processor strobe always reads
  a_r6_cpu_reads: assert property (@(posedge clk) disable iff (rst)
    (!start_cpu_n && !sel1_n && sel2 && !sel3_n && !sleep) |=> (s1_valid && !s1_wr));

  // R9: deselect drops drive after one edge
  a_r9_desel_fast: assert property (@(posedge clk) disable iff (rst)
    (((!start_cpu_n && !sel1_n) || !start_ctl_n) && !(!sel1_n && sel2 && !sel3_n) && !sleep)
      |=> !rdata_drive);

  // R11: sleep accepts no access
  a_r11_sleep_blocks: assert property (@(posedge clk) disable iff (rst)
    sleep |=> !s1_valid);

  always_comb begin
    if (!rst && out_en_n) begin
      a_r10_oe_off: assert (!rdata_drive);  // R10
    end
    if (!rst && sleep) begin
      a_r11_sleep_off: assert (!rdata_drive);  // R11
    end
  end
endmodule

bind pburst_sram pbs_checker u_chk (
  .clk(clk), .rst(rst), .start_cpu_n(start_cpu_n), .start_ctl_n(start_ctl_n),
  .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n), .sleep(sleep),
  .out_en_n(out_en_n), .rdata_drive(rdata_drive),
  .s1_valid(s1_valid), .s1_wr(s1_wr), .burst_act(burst_act)
);

// File: tb/sim_pburst_sram.sv
module sim_pburst_sram;
  localparam int AW = 6;
  localparam int NW = 1 << AW;

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] addr;
  logic          scpu_n, sctl_n, step_n, s1n, s2, s3n;
  logic          wall_n, wbytes_n, lin, oe_n, slp;
  logic [3:0]    lane_n;
  logic [35:0]   din, dout;
  logic          drv;

  logic [35:0]   model [NW];
  int            n_chk = 0;
  int            n_fail = 0;
  int            seq_a [5] = '{6, 6, 7, 7, 4};
  logic          seq_s [4] = '{1'b1, 1'b0, 1'b1, 1'b0};

  always #4 clk = ~clk;

  pburst_sram #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .addr(addr), .start_cpu_n(scpu_n), .start_ctl_n(sctl_n),
    .step_n(step_n), .sel1_n(s1n), .sel2(s2), .sel3_n(s3n), .wr_all_n(wall_n),
    .wr_bytes_n(wbytes_n), .lane_wr_n(lane_n), .order_linear(lin), .out_en_n(oe_n),
    .sleep(slp), .wdata(din), .rdata(dout), .rdata_drive(drv)
  );

  function automatic logic [35:0] patt(int a);
    logic [31:0] t;
    t = 32'(a) * 32'h9E37_79B1;
    return {4'(a) ^ 4'h5, t ^ 32'h0F0F_1234};
  endfunction

  function automatic int beat_of(int base, int i, bit l);
    return l ? ((base + i) % 4) : (base ^ i);
  endfunction

  task automatic quiet();
    scpu_n = 1; sctl_n = 1; step_n = 1; s1n = 0; s2 = 1; s3n = 0;
    wall_n = 1; wbytes_n = 1; lane_n = '1; din = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req, logic [39:0] act, logic [39:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic expect_rd(string req, logic [35:0] exp);
    check(req, {3'b0, drv, dout}, {4'b0001, exp});
  endtask

  task automatic rd1(int a, string req);
    quiet(); scpu_n = 0; addr = AW'(a); tick();
    quiet(); tick();
    expect_rd(req, model[a]);
  endtask

  task automatic rd_burst(int a, bit l, string req);
    quiet(); lin = l; scpu_n = 0; addr = AW'(a); tick();
    for (int i = 1; i < 4; i++) begin
      quiet(); step_n = 0; tick();
      expect_rd(req, model[(a & ~3) | beat_of(a & 3, i - 1, l)]);
    end
    quiet(); tick();
    expect_rd(req, model[(a & ~3) | beat_of(a & 3, 3, l)]);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    logic [35:0] d;
    rst = 1; quiet(); addr = '0; lin = 1; oe_n = 0; slp = 0;
    repeat (3) tick();
    check("R1 drive after reset", {39'b0, drv}, 40'd0);
    rst = 0;
    // R1: stepping with no burst opened gives no read
    quiet(); step_n = 0; tick(); tick();
    check("R1 no burst after reset", {39'b0, drv}, 40'd0);

    // fill with whole-word controller writes (R7, R8)
    for (int a = 0; a < NW; a++) begin
      quiet(); sctl_n = 0; wall_n = 0; addr = AW'(a); din = patt(a);
      model[a] = patt(a); tick();
    end
    quiet(); tick();

    // single processor reads, write inputs active on odd addresses (R2, R6)
    for (int a = 0; a < NW; a++) begin
      quiet(); scpu_n = 0; addr = AW'(a);
      if (a % 2 == 1) begin wall_n = 0; din = ~patt(a); end
      tick(); quiet(); tick();
      expect_rd("R2 single read", model[a]);
    end
    // controller-strobe reads confirm nothing was written (R6, R7)
    for (int a = 1; a < NW; a += 2) begin
      quiet(); sctl_n = 0; addr = AW'(a); tick(); quiet(); tick();
      expect_rd("R6 processor read wrote nothing / R7 controller read", model[a]);
    end

    // burst sweep both orders (R3, R4)
    for (int l = 0; l < 2; l++)
      for (int a = 0; a < NW; a++)
        rd_burst(a, l[0], l ? "R3 linear burst" : "R4 interleaved burst");

    // step hold pattern (R5)
    quiet(); lin = 1; scpu_n = 0; addr = 6'd6; tick();
    for (int i = 0; i < 4; i++) begin
      quiet(); step_n = seq_s[i]; tick();
      expect_rd("R5 step hold", model[seq_a[i]]);
    end
    quiet(); tick();
    expect_rd("R5 step hold", model[seq_a[4]]);

    // lane writes under every mask (R8)
    for (int m = 0; m < 16; m++) begin
      quiet(); sctl_n = 0; wbytes_n = 0; lane_n = ~4'(m); addr = 6'd10;
      din = patt(m + 100);
      for (int b = 0; b < 4; b++)
        if (m[b]) model[10][b*9 +: 9] = din[b*9 +: 9];
      tick();
      rd1(10, "R8 lane write");
    end
    // lane enables without the qualifier do nothing
    quiet(); sctl_n = 0; lane_n = '0; addr = 6'd10; din = 36'h0_1234_5678; tick();
    rd1(10, "R8 lane enables ignored without qualifier");
    // whole-word write overrides the lane enables
    quiet(); sctl_n = 0; wall_n = 0; wbytes_n = 0; lane_n = 4'b1110; addr = 6'd11;
    din = 36'h9_8765_4321; model[11] = din; tick();
    rd1(11, "R8 whole-word write");

    // controller burst write in interleaved order (R7, R4)
    quiet(); lin = 0; sctl_n = 0; wall_n = 0; addr = 6'd13; din = patt(200);
    model[13] = din; tick();
    for (int i = 1; i < 4; i++) begin
      quiet(); step_n = 0; wall_n = 0; din = patt(200 + i);
      model[12 | (1 ^ i)] = din; tick();
    end
    quiet(); tick();
    rd_burst(13, 1'b0, "R7 controller burst write");

    // both strobes: processor wins and reads (R7)
    quiet(); scpu_n = 0; sctl_n = 0; wall_n = 0; addr = 6'd20; din = 36'hF_FFFF_0000;
    tick(); quiet(); tick();
    expect_rd("R7 both strobes read", model[20]);
    rd1(20, "R7 both strobes wrote nothing");

    // deselect, then blocked processor strobe (R9, R6)
    quiet(); sctl_n = 0; s2 = 0; tick();
    check("R9 deselect drops drive", {39'b0, drv}, 40'd0);
    quiet(); s1n = 1; scpu_n = 0; wall_n = 0; addr = 6'd21; din = 36'h0; tick();
    quiet(); tick();
    check("R6 blocked processor strobe", {39'b0, drv}, 40'd0);
    rd1(21, "R6 blocked strobe wrote nothing");

    // deselect / select latency (R9)
    quiet(); lin = 1; scpu_n = 0; addr = 6'd24; tick();
    quiet(); step_n = 0; tick();
    expect_rd("R9 before deselect", model[24]);
    quiet(); sctl_n = 0; s3n = 1; tick();
    check("R9 one edge to deselect", {39'b0, drv}, 40'd0);
    quiet(); scpu_n = 0; addr = 6'd25; tick();
    check("R9 select not yet driven", {39'b0, drv}, 40'd0);
    quiet(); tick();
    expect_rd("R9 select after two edges", model[25]);

    // asynchronous output enable (R10)
    oe_n = 1; #1;
    check("R10 output enable off", {39'b0, drv}, 40'd0);
    oe_n = 0; #1;
    check("R10 output enable on", {39'b0, drv}, 40'd1);

    // sleep during a burst (R11)
    tick();
    quiet(); scpu_n = 0; addr = 6'd28; tick();
    quiet(); step_n = 0; tick();
    expect_rd("R11 before sleep", model[28]);
    quiet(); slp = 1; sctl_n = 0; wall_n = 0; step_n = 0; addr = 6'd28; din = 36'h0; #1;
    check("R11 sleep drops drive", {39'b0, drv}, 40'd0);
    tick(); tick();
    check("R11 drive off while asleep", {39'b0, drv}, 40'd0);
    slp = 0; quiet(); step_n = 0; tick();
    quiet(); tick();
    expect_rd("R11 burst resumes from held beat", model[30]);
    rd1(28, "R11 no write while asleep");

    report();
    $finish;
  end
endmodule